// File: doc/BRIEF.md
# Fractional Duty to Compare Word Mapper

This block converts a per-unit duty command into the compare word that a pulse width modulator with sub-clock edge placement consumes. The command is an unsigned Q15 fraction. It is multiplied by the PWM period, which is given in clock counts. The integer part of that product becomes a 16-bit coarse compare value. The fractional part is converted into fine edge steps by multiplying it by a scale factor, which gives the number of fine steps in one clock. An offset of one and a half steps is added to that fine value. The offset rounds the value and keeps it away from the bottom of its range.

The coarse value and the fine byte are packed into one 32-bit word, so that a controller can write both halves in a single access. Near the start of the period the fine edge hardware is not yet running. For coarse values inside that blanking window, the fine byte is forced to zero. The window is selectable as 3 or 6 clocks.

The datapath is a three-stage pipeline:
- Stage one registers the duty-by-period product.
- Stage two splits the product and registers the scaled and offset fraction.
- Stage three saturates, blanks, packs and registers the output.

The pipeline accepts one command per clock and keeps results in order.

Top module: `duty_cmp_mapper`

## Requirements
- R1: The coarse field, bits 31:16 of `out_word`, equals floor(duty × period / 32768). The duty is a 15-bit unsigned value that stands for duty/32768.
- R2: The fine field, bits 15:8, equals floor(frac × scale / 32768 + 1.5). Here frac is the remainder (duty × period) mod 32768, and scale is an integer from 1 to 255.
- R3: Bits 7:0 of `out_word` are always zero.
- R4: When the fine sum reaches 256 or more, the fine field saturates at 255 (0xFF).
- R5: With `in_blank_long` = 0 the blanking threshold is 3; with `in_blank_long` = 1 it is 6. A coarse value below the threshold forces the fine field to 0. A coarse value equal to the threshold is not blanked.
- R6: A duty of zero yields an all-zero output word.
- R7: `out_valid` rises exactly three clocks after the `in_valid` cycle that it belongs to. One command per clock is accepted, and results leave in the order the commands arrived.
- R8: Asynchronous active-low reset clears `out_valid` and `out_word` to zero and drops every command still in the pipeline.
- R9: While `out_valid` is low, `out_word` keeps the last result it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command present this cycle |
| in_duty | input | 15 | Unsigned Q15 duty fraction |
| in_period | input | 16 | PWM period in clock counts |
| in_scale | input | 8 | Fine steps per clock, 1 to 255 |
| in_blank_long | input | 1 | 0 selects a 3-clock blanking window, 1 selects a 6-clock window |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | Coarse value in bits 31:16, fine byte in bits 15:8, zeros in bits 7:0 |

## Verification
The assertions assume that every accepted command carries a nonzero scale factor. They also assume that the period sampled alongside a command is the period that command was computed against. Under those assumptions they can bound the coarse result by the period and tie zero duty to a zero word.

The stimulus table and the directed cases use only scale values from 1 to 255. The directed cases cover the saturation point, both blanking windows with coarse values just under and exactly at the threshold, and a reset that lands while a command is still in flight.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    // Selects how long the fine edge stays blanked after the period starts.
    typedef enum logic {
        BLANK_SHORT = 1'b0,
        BLANK_LONG  = 1'b1
    } blank_mode_e;

    localparam int unsigned BLANK_SHORT_CYC = 3;
    localparam int unsigned BLANK_LONG_CYC  = 6;

    // Number of register stages between the input and the output.
    localparam int unsigned PIPE_DEPTH = 3;

endpackage

// File: rtl/dcm_mul_stage.sv
// Stage one: register the duty-by-period product together with its side data.
module dcm_mul_stage
    import dcm_pkg::*;
#(
    parameter int unsigned DUTY_W = 15,
    parameter int unsigned PER_W  = 16,
    parameter int unsigned SCL_W  = 8,
    localparam int unsigned PROD_W = DUTY_W + PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic [DUTY_W-1:0] i_duty,
    input  logic [PER_W-1:0]  i_period,
    input  logic [SCL_W-1:0]  i_scale,
    input  blank_mode_e       i_mode,
    output logic              o_valid,
    output logic [PROD_W-1:0] o_prod,
    output logic [SCL_W-1:0]  o_scale,
    output blank_mode_e       o_mode
);

    logic [PROD_W-1:0] prod_d;

    // Both operands are widened to the product width, so no bits are lost.
    always_comb begin
        prod_d = {{PER_W{1'b0}}, i_duty} * {{DUTY_W{1'b0}}, i_period};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
        end else begin
            o_valid <= i_valid;
        end
    end

    // Data registers load only with a command, so idle cycles leave them alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_prod  <= '0;
            o_scale <= '0;
            o_mode  <= BLANK_SHORT;
        end else if (i_valid) begin
            o_prod  <= prod_d;
            o_scale <= i_scale;
            o_mode  <= i_mode;
        end
    end

endmodule

// File: rtl/dcm_fine_stage.sv
// Stage two: split the product, scale the fraction and add the 1.5-step offset.
module dcm_fine_stage
    import dcm_pkg::*;
#(
    parameter int unsigned DUTY_W = 15,
    parameter int unsigned PER_W  = 16,
    parameter int unsigned SCL_W  = 8,
    localparam int unsigned PROD_W = DUTY_W + PER_W,
    localparam int unsigned SUM_W  = DUTY_W + SCL_W + 1,
    localparam int unsigned INT_W  = SCL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic [PROD_W-1:0] i_prod,
    input  logic [SCL_W-1:0]  i_scale,
    input  blank_mode_e       i_mode,
    output logic              o_valid,
    output logic [PER_W-1:0]  o_coarse,
    output logic [INT_W-1:0]  o_fine_int,
    output blank_mode_e       o_mode
);

    // 1.5 expressed with DUTY_W fraction bits: 3 shifted up by (DUTY_W-1).
    localparam logic [SUM_W-1:0] ROUND_OFS = SUM_W'(3) << (DUTY_W - 1);

    logic [PER_W-1:0]  coarse_d;
    logic [DUTY_W-1:0] frac_d;
    logic [SUM_W-1:0]  sum_d;

    always_comb begin
        coarse_d = i_prod[PROD_W-1:DUTY_W];
        frac_d   = i_prod[DUTY_W-1:0];
        // The sum keeps the full DUTY_W fraction bits, so only one truncation happens.
        sum_d    = {{(SCL_W + 1){1'b0}}, frac_d} * {{(DUTY_W + 1){1'b0}}, i_scale}
                 + ROUND_OFS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
        end else begin
            o_valid <= i_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_coarse   <= '0;
            o_fine_int <= '0;
            o_mode     <= BLANK_SHORT;
        end else if (i_valid) begin
            o_coarse   <= coarse_d;
            o_fine_int <= sum_d[SUM_W-1:DUTY_W];
            o_mode     <= i_mode;
        end
    end

endmodule

// File: rtl/dcm_pack_stage.sv
// Stage three: saturate the fine value, apply blanking and pack the output word.
module dcm_pack_stage
    import dcm_pkg::*;
#(
    parameter int unsigned PER_W  = 16,
    parameter int unsigned SCL_W  = 8,
    parameter int unsigned FINE_W = 8,
    localparam int unsigned INT_W  = SCL_W + 1,
    localparam int unsigned WORD_W = PER_W + 2 * FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic [PER_W-1:0]  i_coarse,
    input  logic [INT_W-1:0]  i_fine_int,
    input  blank_mode_e       i_mode,
    output logic              o_valid,
    output logic [WORD_W-1:0] o_word
);

    localparam logic [PER_W-1:0] THR_SHORT = PER_W'(BLANK_SHORT_CYC);
    localparam logic [PER_W-1:0] THR_LONG  = PER_W'(BLANK_LONG_CYC);

    logic [FINE_W-1:0] fine_sat;
    logic [FINE_W-1:0] fine_fin;
    logic [PER_W-1:0]  thr;

    // The saturation logic depends on whether the integer part can exceed the fine field.
    generate
        if (INT_W > FINE_W) begin : g_sat
            always_comb begin
                if (i_fine_int > INT_W'({FINE_W{1'b1}})) begin
                    fine_sat = {FINE_W{1'b1}};
                end else begin
                    fine_sat = i_fine_int[FINE_W-1:0];
                end
            end
        end else begin : g_nosat
            always_comb begin
                fine_sat = FINE_W'(i_fine_int);
            end
        end
    endgenerate

    always_comb begin
        unique case (i_mode)
            BLANK_SHORT: thr = THR_SHORT;
            BLANK_LONG:  thr = THR_LONG;
            default:     thr = THR_LONG;
        endcase
        fine_fin = (i_coarse < thr) ? '0 : fine_sat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
        end else begin
            o_valid <= i_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_word <= '0;
        end else if (i_valid) begin
            o_word <= {i_coarse, fine_fin, {FINE_W{1'b0}}};
        end
    end

endmodule

// File: rtl/duty_cmp_mapper.sv
module duty_cmp_mapper
    import dcm_pkg::*;
#(
    parameter int unsigned DUTY_W = 15,
    parameter int unsigned PER_W  = 16,
    parameter int unsigned SCL_W  = 8,
    parameter int unsigned FINE_W = 8,
    localparam int unsigned PROD_W = DUTY_W + PER_W,
    localparam int unsigned INT_W  = SCL_W + 1,
    localparam int unsigned WORD_W = PER_W + 2 * FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DUTY_W-1:0] in_duty,
    input  logic [PER_W-1:0]  in_period,
    input  logic [SCL_W-1:0]  in_scale,
    input  logic              in_blank_long,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    // Signals between stage one and stage two.
    logic              s1_valid;
    logic [PROD_W-1:0] s1_prod;
    logic [SCL_W-1:0]  s1_scale;
    blank_mode_e       s1_mode;

    // Signals between stage two and stage three.
    logic              s2_valid;
    logic [PER_W-1:0]  s2_coarse;
    logic [INT_W-1:0]  s2_fine_int;
    blank_mode_e       s2_mode;

    blank_mode_e       in_mode;

    always_comb begin
        in_mode = in_blank_long ? BLANK_LONG : BLANK_SHORT;
    end

    dcm_mul_stage #(
        .DUTY_W (DUTY_W),
        .PER_W  (PER_W),
        .SCL_W  (SCL_W)
    ) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_valid  (in_valid),
        .i_duty   (in_duty),
        .i_period (in_period),
        .i_scale  (in_scale),
        .i_mode   (in_mode),
        .o_valid  (s1_valid),
        .o_prod   (s1_prod),
        .o_scale  (s1_scale),
        .o_mode   (s1_mode)
    );

    dcm_fine_stage #(
        .DUTY_W (DUTY_W),
        .PER_W  (PER_W),
        .SCL_W  (SCL_W)
    ) u_fine (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_valid    (s1_valid),
        .i_prod     (s1_prod),
        .i_scale    (s1_scale),
        .i_mode     (s1_mode),
        .o_valid    (s2_valid),
        .o_coarse   (s2_coarse),
        .o_fine_int (s2_fine_int),
        .o_mode     (s2_mode)
    );

    dcm_pack_stage #(
        .PER_W  (PER_W),
        .SCL_W  (SCL_W),
        .FINE_W (FINE_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_valid    (s2_valid),
        .i_coarse   (s2_coarse),
        .i_fine_int (s2_fine_int),
        .i_mode     (s2_mode),
        .o_valid    (out_valid),
        .o_word     (out_word)
    );

endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
    parameter int unsigned DUTY_W = 15,
    parameter int unsigned PER_W  = 16,
    parameter int unsigned SCL_W  = 8,
    parameter int unsigned FINE_W = 8,
    localparam int unsigned WORD_W = PER_W + 2 * FINE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DUTY_W-1:0] in_duty,
    input logic [PER_W-1:0]  in_period,
    input logic [SCL_W-1:0]  in_scale,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word
);

    // Input history over the fixed pipeline depth of three.
    logic [2:0]       vhist;
    logic [2:0]       zhist;
    logic [PER_W-1:0] phist [3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vhist <= '0;
            zhist <= '0;
            for (int k = 0; k < 3; k++) begin
                phist[k] <= '0;
            end
        end else begin
            vhist    <= {vhist[1:0], in_valid};
            zhist    <= {zhist[1:0], in_valid && (in_duty == '0)};
            phist[0] <= in_period;
            phist[1] <= phist[0];
            phist[2] <= phist[1];
        end
    end

    logic [PER_W-1:0]  coarse_o;
    logic [FINE_W-1:0] fine_o;

    always_comb begin
        coarse_o = out_word[WORD_W-1:2*FINE_W];
        fine_o   = out_word[2*FINE_W-1:FINE_W];
    end

    // R2: input assumption, every accepted command carries a nonzero scale.
    p_scale_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_scale != '0));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[2]);

    p_coarse_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((coarse_o < phist[2]) || (coarse_o == '0)));

    p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zhist[2]) |-> (out_word == '0));

    p_blank_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (coarse_o < PER_W'(3))) |-> (fine_o == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

endmodule

bind duty_cmp_mapper dcm_checker #(
    .DUTY_W (DUTY_W),
    .PER_W  (PER_W),
    .SCL_W  (SCL_W),
    .FINE_W (FINE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_duty   (in_duty),
    .in_period (in_period),
    .in_scale  (in_scale),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/sim_duty_cmp_mapper.sv
module sim_duty_cmp_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [14:0] in_duty = '0;
    logic [15:0] in_period = '0;
    logic [7:0]  in_scale = 8'd1;
    logic        in_blank_long = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;

    // 50 MHz clock.
    always #10 clk = ~clk;

    duty_cmp_mapper u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_duty       (in_duty),
        .in_period     (in_period),
        .in_scale      (in_scale),
        .in_blank_long (in_blank_long),
        .out_valid     (out_valid),
        .out_word      (out_word)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Each stimulus vector packs {duty[14:0], period[15:0], scale[7:0], blank_long}.
    localparam int NV = 13;
    localparam logic [39:0] VEC [NV] = '{
        {15'd13271, 16'd80,    8'd55,  1'b0},
        {15'd0,     16'd80,    8'd55,  1'b0},
        {15'd32767, 16'd10,    8'd255, 1'b0},
        {15'd32767, 16'd10,    8'd200, 1'b0},
        {15'd1700,  16'd80,    8'd55,  1'b0},
        {15'd1700,  16'd80,    8'd55,  1'b1},
        {15'd16384, 16'd65535, 8'd128, 1'b0},
        {15'd32767, 16'd65535, 8'd1,   1'b1},
        {15'd1,     16'd65535, 8'd255, 1'b0},
        {15'd12345, 16'd1000,  8'd66,  1'b1},
        {15'd20000, 16'd7,     8'd99,  1'b0},
        {15'd5000,  16'd40000, 8'd180, 1'b1},
        {15'd0,     16'd65535, 8'd255, 1'b1}
    };

    // Reference model written from the requirements.
    function automatic logic [31:0] model(input logic [14:0] d, input logic [15:0] p,
                                          input logic [7:0] s, input logic bl);
        longint prod;
        longint coarse;
        longint frac;
        longint fine;
        prod   = longint'(d) * longint'(p);
        coarse = prod / 32768;
        frac   = prod % 32768;
        fine   = (frac * longint'(s) + 49152) / 32768;
        if (fine > 255) fine = 255;
        if (coarse < (bl ? 6 : 3)) fine = 0;
        return {coarse[15:0], fine[7:0], 8'h00};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [14:0] d, input logic [15:0] p, input logic [7:0] s,
                           input logic bl, input logic [31:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_duty = d; in_period = p; in_scale = s; in_blank_long = bl;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 early valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7 valid", {31'd0, out_valid}, 32'd1);
        check(out_word == exp, tag, out_word, exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid low", {31'd0, out_valid}, 32'd0);
        check(out_word == exp, "R9 hold", out_word, exp);
    endtask

    initial begin
        logic [31:0] expq [$];
        logic [31:0] e;
        repeat (3) @(negedge clk);
        // R8: reset state.
        check(out_valid == 1'b0, "R8 reset valid", {31'd0, out_valid}, 32'd0);
        check(out_word == 32'd0, "R8 reset word", out_word, 32'd0);
        rst_n = 1'b1;

        // Back-to-back stream: one result per clock, in order, three clocks late (R7).
        for (int i = 0; i < NV + 4; i++) begin
            @(negedge clk);
            if (i >= 3 && i - 3 < NV) begin
                e = expq.pop_front();
                check(out_valid == 1'b1, "R7 stream valid", {31'd0, out_valid}, 32'd1);
                check(out_word == e, "R1 R2 R3 R5 R6 stream word", out_word, e);
            end else begin
                check(out_valid == 1'b0, "R7 stream idle", {31'd0, out_valid}, 32'd0);
            end
            if (i < NV) begin
                in_valid      = 1'b1;
                in_duty       = VEC[i][39:25];
                in_period     = VEC[i][24:9];
                in_scale      = VEC[i][8:1];
                in_blank_long = VEC[i][0];
                expq.push_back(model(VEC[i][39:25], VEC[i][24:9], VEC[i][8:1], VEC[i][0]));
            end else begin
                in_valid = 1'b0;
            end
        end

        // Directed cases with hand-computed words.
        run_one(15'd13271, 16'd80, 8'd55,  1'b0, 32'h0020_1700, "R1 R2 worked example");
        run_one(15'd32767, 16'd10, 8'd255, 1'b0, 32'h0009_FF00, "R4 saturation");
        run_one(15'd1700,  16'd80, 8'd55,  1'b0, 32'h0004_0900, "R5 short window passes");
        run_one(15'd1700,  16'd80, 8'd55,  1'b1, 32'h0004_0000, "R5 long window blanks");
        run_one(15'd2500,  16'd80, 8'd55,  1'b1, 32'h0006_0700, "R5 at threshold");
        run_one(15'd1229,  16'd80, 8'd55,  1'b0, 32'h0003_0000 | (32'(((1229*80)%32768*55+49152)/32768) << 8),
                "R5 short threshold");
        run_one(15'd0,     16'd999, 8'd200, 1'b1, 32'h0000_0000, "R6 zero duty");

        // R8: reset while a command is in flight drops it.
        @(negedge clk);
        in_valid = 1'b1; in_duty = 15'd20000; in_period = 16'd500; in_scale = 8'd77;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 mid reset valid", {31'd0, out_valid}, 32'd0);
        check(out_word == 32'd0, "R8 mid reset word", out_word, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8 dropped command", {31'd0, out_valid}, 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule